// File: doc/BRIEF.md
# Dual-Channel Codec Loopback and Power-Down Controller

This block sits between a host sample interface and the converters of a two-channel codec, one channel for data and one for voice. Each channel has one programmable control register. Three bits of it choose how the channel's sample streams are routed: normal operation, a converter-side echo in which what the host sends to the DAC comes back as the ADC result, or a host-side echo in which the ADC result is sent straight back into the DAC. A fourth bit puts the channel into software power-down. Power-down clears the channel's internal counters but leaves its control register as programmed.

Each channel runs its own sample-rate divider. The divider sets the sample boundaries at which samples are emitted and at which new register values take effect. Between two boundaries the incoming samples are held, and the most recent one is kept. At the boundary the routing selected by the active configuration sends each held sample out on the matching output stream with a one-cycle valid strobe. The two channels share only the register write port. They never exchange samples.

Top module: `codec_loop_ctrl`

## Requirements
- R1: After reset both control registers are zero, both channels are in normal routing and powered up, all valid outputs are low, and the divider and boundary counters read zero.
- R2: A write to address 1 loads the data channel (channel 0) register and a write to address 3 loads the voice channel (channel 1) register. Writes to any other address change nothing. Bit 4 selects converter-side echo, bit 5 selects host-side echo and bit 6 selects power-down.
- R3: In normal routing (bits 4 and 5 clear), the DAC output carries the host transmit sample and the host receive output carries the ADC sample.
- R4: With only bit 4 set, the host receive output carries the host transmit sample, and the DAC output also carries that sample.
- R5: With bit 5 set, the DAC output carries the ADC sample and the host receive output also carries the ADC sample. This holds whatever the value of bit 4.
- R6: Each channel's divider counts DIV clock cycles per sample. `sync_o` pulses for one cycle at every boundary. An output valid rises in the cycle after `sync_o`, and only if its source received a sample since the previous boundary, including in the boundary cycle itself. The latest such sample is the one emitted.
- R7: A register write takes effect at the channel's next boundary. A write accepted in a `sync_o` cycle takes effect at the boundary after that one.
- R8: Power-down takes effect at a boundary. While a channel is powered down, its `sync_o` and valid outputs stay low, its counters read zero and incoming samples are discarded. Clearing bit 6 takes effect on the next clock, and the divider then restarts from zero. A channel that is powered down keeps its register contents and does not leave power-down by itself.
- R9: A channel's configuration, power-down and samples never affect the other channel.
- R10: `frame_cnt_o` counts the boundaries of each channel and wraps at 2^CW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Register write address |
| wr_data_i | input | RW | Register write data |
| adc_data_i | input | NCH*SW | ADC result sample per channel |
| adc_valid_i | input | NCH | ADC result valid per channel |
| tx_data_i | input | NCH*SW | Host transmit sample per channel |
| tx_valid_i | input | NCH | Host transmit valid per channel |
| dac_data_o | output | NCH*SW | Sample to DAC per channel |
| dac_valid_o | output | NCH | DAC sample valid per channel |
| rx_data_o | output | NCH*SW | Sample to host per channel |
| rx_valid_o | output | NCH | Host sample valid per channel |
| sync_o | output | NCH | Sample boundary strobe per channel |
| frame_cnt_o | output | NCH*CW | Boundary count per channel |

## Verification
Two events can land in the same cycle: a register write and a sample boundary, and also a sample arrival and a boundary. The bench waits for `sync_o` of a channel and issues the write in that exact cycle. It also keeps driving random sample strobes, so arrivals regularly coincide with boundaries. A behavioural model applies the write one boundary late and folds a coincident sample into the current emission. Every clock, the model is compared with the routed data, the valids, `sync_o` and the counters. Power-down is entered through such a coincident write on one channel while the other channel keeps running, so the two channels can be judged against each other.

// File: rtl/codec_lc_pkg.sv
package codec_lc_pkg;
  localparam int unsigned BIT_ALB = 4;  // converter-side echo
  localparam int unsigned BIT_DLB = 5;  // host-side echo
  localparam int unsigned BIT_PD  = 6;  // software power-down

  typedef enum logic [1:0] {
    MODE_NORM = 2'd0,
    MODE_ALB  = 2'd1,
    MODE_DLB  = 2'd2
  } route_e;

  function automatic route_e route_mode(input logic alb, input logic dlb);
    if (dlb)      return MODE_DLB;
    else if (alb) return MODE_ALB;
    else          return MODE_NORM;
  endfunction
endpackage

// File: rtl/codec_lc_regs.sv
module codec_lc_regs #(
  parameter int unsigned NCH = 2,
  parameter int unsigned AW  = 2,
  parameter int unsigned RW  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [RW-1:0]     wr_data_i,
  output logic [NCH*RW-1:0] cfg_o
);
  logic [NCH-1:0] hit;

  for (genvar c = 0; c < NCH; c++) begin : g_reg
    localparam logic [AW-1:0] ADDR = AW'(2 * c + 1);
    logic [RW-1:0] cfg_q;
    assign hit[c] = wr_en_i && (wr_addr_i == ADDR);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cfg_q <= '0;
      else if (hit[c]) cfg_q <= wr_data_i;
    end
    assign cfg_o[c*RW +: RW] = cfg_q;
  end

  AST_STRAY_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hit == '0) |=> $stable(cfg_o)); // R2
endmodule

// File: rtl/codec_lc_timer.sv
module codec_lc_timer
  import codec_lc_pkg::*;
#(
  parameter int unsigned DIV = 8,
  parameter int unsigned CW  = 8,
  parameter int unsigned RW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] cfg_i,
  output logic [RW-1:0] cfg_act_o,
  output logic          tick_o,
  output logic          pd_o,
  output logic          blk_o,
  output logic [CW-1:0] frame_cnt_o
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);

  logic [RW-1:0] act_q, act_d;
  logic [DW-1:0] div_q, div_d;
  logic [CW-1:0] frm_q, frm_d;
  logic          pd_q, pd_nxt, tick;

  assign pd_q   = act_q[BIT_PD];
  assign tick   = !pd_q && (div_q == DIV_LAST);
  // config is sampled at a boundary, or at any cycle while powered down
  assign act_d  = (tick || pd_q) ? cfg_i : act_q;
  assign pd_nxt = act_d[BIT_PD];

  always_comb begin
    div_d = div_q + DW'(1);
    if (pd_q || pd_nxt || tick) div_d = '0;
    frm_d = frm_q;
    if (pd_nxt)    frm_d = '0;
    else if (tick) frm_d = frm_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      div_q <= '0;
      frm_q <= '0;
    end else begin
      act_q <= act_d;
      div_q <= div_d;
      frm_q <= frm_d;
    end
  end

  assign cfg_act_o   = act_q;
  assign tick_o      = tick;
  assign pd_o        = pd_q;
  assign blk_o       = pd_q || pd_nxt;
  assign frame_cnt_o = frm_q;

  AST_PD_CNT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_q |-> (div_q == '0 && frm_q == '0)); // R8
  AST_CFG_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(tick) && !$past(pd_q)) |-> $stable(act_q)); // R7
  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> !tick); // R6
endmodule

// File: rtl/codec_lc_route.sv
module codec_lc_route
  import codec_lc_pkg::*;
#(
  parameter int unsigned SW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          blk_i,
  input  logic          pd_i,
  input  logic          alb_i,
  input  logic          dlb_i,
  input  logic [SW-1:0] adc_data_i,
  input  logic          adc_valid_i,
  input  logic [SW-1:0] tx_data_i,
  input  logic          tx_valid_i,
  output logic [SW-1:0] dac_data_o,
  output logic          dac_valid_o,
  output logic [SW-1:0] rx_data_o,
  output logic          rx_valid_o
);
  route_e        mode;
  logic [SW-1:0] tx_hold_q, adc_hold_q, tx_cur, adc_cur;
  logic          tx_pend_q, adc_pend_q, tx_av, adc_av;
  logic [SW-1:0] dac_q, rx_q;
  logic          dac_v_q, rx_v_q;

  assign mode    = route_mode(alb_i, dlb_i);
  // a sample landing on the boundary joins that boundary
  assign tx_av   = tx_valid_i || tx_pend_q;
  assign adc_av  = adc_valid_i || adc_pend_q;
  assign tx_cur  = tx_valid_i ? tx_data_i : tx_hold_q;
  assign adc_cur = adc_valid_i ? adc_data_i : adc_hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_hold_q  <= '0;
      adc_hold_q <= '0;
      tx_pend_q  <= 1'b0;
      adc_pend_q <= 1'b0;
    end else begin
      if (tx_valid_i)  tx_hold_q  <= tx_data_i;
      if (adc_valid_i) adc_hold_q <= adc_data_i;
      if (blk_i || tick_i) begin
        tx_pend_q  <= 1'b0;
        adc_pend_q <= 1'b0;
      end else begin
        tx_pend_q  <= tx_pend_q || tx_valid_i;
        adc_pend_q <= adc_pend_q || adc_valid_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_q   <= '0;
      rx_q    <= '0;
      dac_v_q <= 1'b0;
      rx_v_q  <= 1'b0;
    end else begin
      dac_v_q <= 1'b0;
      rx_v_q  <= 1'b0;
      if (tick_i) begin
        unique case (mode)
          MODE_DLB: begin
            dac_q <= adc_cur; dac_v_q <= adc_av;
            rx_q  <= adc_cur; rx_v_q  <= adc_av;
          end
          MODE_ALB: begin
            dac_q <= tx_cur;  dac_v_q <= tx_av;
            rx_q  <= tx_cur;  rx_v_q  <= tx_av;
          end
          default: begin
            dac_q <= tx_cur;  dac_v_q <= tx_av;
            rx_q  <= adc_cur; rx_v_q  <= adc_av;
          end
        endcase
      end
    end
  end

  assign dac_data_o  = dac_q;
  assign dac_valid_o = dac_v_q;
  assign rx_data_o   = rx_q;
  assign rx_valid_o  = rx_v_q;

  AST_VALID_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_valid_o || rx_valid_o) |-> $past(tick_i)); // R6
  AST_PD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_i && $past(pd_i)) |-> (!dac_valid_o && !rx_valid_o)); // R8
  AST_ALB_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && $past(mode == MODE_ALB)) |-> (dac_valid_o && rx_data_o == dac_data_o)); // R4
  AST_DLB_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_valid_o && $past(mode == MODE_DLB)) |-> (rx_valid_o && rx_data_o == dac_data_o)); // R5
endmodule

// File: rtl/codec_loop_ctrl.sv
module codec_loop_ctrl
  import codec_lc_pkg::*;
#(
  parameter int unsigned NCH = 2,
  parameter int unsigned AW  = 2,
  parameter int unsigned RW  = 8,
  parameter int unsigned SW  = 16,
  parameter int unsigned DIV = 8,
  parameter int unsigned CW  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [RW-1:0]     wr_data_i,
  input  logic [NCH*SW-1:0] adc_data_i,
  input  logic [NCH-1:0]    adc_valid_i,
  input  logic [NCH*SW-1:0] tx_data_i,
  input  logic [NCH-1:0]    tx_valid_i,
  output logic [NCH*SW-1:0] dac_data_o,
  output logic [NCH-1:0]    dac_valid_o,
  output logic [NCH*SW-1:0] rx_data_o,
  output logic [NCH-1:0]    rx_valid_o,
  output logic [NCH-1:0]    sync_o,
  output logic [NCH*CW-1:0] frame_cnt_o
);
  logic [NCH*RW-1:0] cfg;

  codec_lc_regs #(.NCH(NCH), .AW(AW), .RW(RW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .cfg_o    (cfg)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [RW-1:0] act;
    logic          tick, pd, blk;

    codec_lc_timer #(.DIV(DIV), .CW(CW), .RW(RW)) u_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_i      (cfg[c*RW +: RW]),
      .cfg_act_o  (act),
      .tick_o     (tick),
      .pd_o       (pd),
      .blk_o      (blk),
      .frame_cnt_o(frame_cnt_o[c*CW +: CW])
    );

    codec_lc_route #(.SW(SW)) u_route (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick),
      .blk_i      (blk),
      .pd_i       (pd),
      .alb_i      (act[BIT_ALB]),
      .dlb_i      (act[BIT_DLB]),
      .adc_data_i (adc_data_i[c*SW +: SW]),
      .adc_valid_i(adc_valid_i[c]),
      .tx_data_i  (tx_data_i[c*SW +: SW]),
      .tx_valid_i (tx_valid_i[c]),
      .dac_data_o (dac_data_o[c*SW +: SW]),
      .dac_valid_o(dac_valid_o[c]),
      .rx_data_o  (rx_data_o[c*SW +: SW]),
      .rx_valid_o (rx_valid_o[c])
    );

    assign sync_o[c] = tick;

    AST_SYNC_QUIET_IN_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pd |-> !sync_o[c]); // R8
  end
endmodule

// File: tb/codec_loop_ctrl_tb.sv
module codec_loop_ctrl_tb_top;
  localparam int NCH = 2, AW = 2, RW = 8, SW = 16, DIV = 8, CW = 8;

  logic              clk = 1'b0, rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [AW-1:0]     wr_addr = '0;
  logic [RW-1:0]     wr_data = '0;
  logic [NCH*SW-1:0] adc_data = '0, tx_data = '0;
  logic [NCH-1:0]    adc_valid = '0, tx_valid = '0;
  logic [NCH*SW-1:0] dac_data, rx_data;
  logic [NCH-1:0]    dac_valid, rx_valid, sync;
  logic [NCH*CW-1:0] frame_cnt;

  always #4 clk = ~clk;  // 125 MHz

  codec_loop_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .adc_data_i(adc_data), .adc_valid_i(adc_valid),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .dac_data_o(dac_data), .dac_valid_o(dac_valid),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .sync_o(sync), .frame_cnt_o(frame_cnt)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_reg[NCH], m_act[NCH], m_div[NCH], m_frm[NCH];
  int m_txp[NCH], m_adp[NCH], m_txh[NCH], m_adh[NCH];
  int m_dv[NCH], m_dd[NCH], m_rv[NCH], m_rd[NCH];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_reg[c] = 0; m_act[c] = 0; m_div[c] = 0; m_frm[c] = 0;
        m_txp[c] = 0; m_adp[c] = 0; m_txh[c] = 0; m_adh[c] = 0;
        m_dv[c] = 0; m_dd[c] = 0; m_rv[c] = 0; m_rd[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        automatic int pd  = (m_act[c] >> 6) & 1;
        automatic int tk  = (!pd && m_div[c] == DIV - 1) ? 1 : 0;
        automatic int nact = (tk || pd) ? m_reg[c] : m_act[c];
        automatic int npd = (nact >> 6) & 1;
        automatic int txv = int'(tx_valid[c]);
        automatic int adv = int'(adc_valid[c]);
        automatic int txd = int'(tx_data[c*SW +: SW]);
        automatic int add = int'(adc_data[c*SW +: SW]);
        automatic int txa = txv | m_txp[c];
        automatic int ada = adv | m_adp[c];
        automatic int txc = txv ? txd : m_txh[c];
        automatic int adc = adv ? add : m_adh[c];
        automatic int dlb = (m_act[c] >> 5) & 1;
        automatic int alb = (m_act[c] >> 4) & 1;
        m_dv[c] = 0; m_rv[c] = 0;
        if (tk) begin
          if (dlb) begin m_dd[c] = adc; m_dv[c] = ada; m_rd[c] = adc; m_rv[c] = ada; end
          else if (alb) begin m_dd[c] = txc; m_dv[c] = txa; m_rd[c] = txc; m_rv[c] = txa; end
          else begin m_dd[c] = txc; m_dv[c] = txa; m_rd[c] = adc; m_rv[c] = ada; end
        end
        if (txv) m_txh[c] = txd;
        if (adv) m_adh[c] = add;
        if (pd || npd || tk) begin m_txp[c] = 0; m_adp[c] = 0; end
        else begin m_txp[c] = txa; m_adp[c] = ada; end
        m_div[c] = (pd || npd || tk) ? 0 : m_div[c] + 1;
        if (npd) m_frm[c] = 0;
        else if (tk) m_frm[c] = (m_frm[c] + 1) % (1 << CW);
        m_act[c] = nact;
        if (wr_en && int'(wr_addr) == 2 * c + 1) m_reg[c] = int'(wr_data);
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < NCH; c++) begin
        automatic int pd = (m_act[c] >> 6) & 1;
        automatic int es = (!pd && m_div[c] == DIV - 1) ? 1 : 0;
        chk(int'(sync[c]) == es, "R6 sync", int'(sync[c]), es);
        chk(int'(frame_cnt[c*CW +: CW]) == m_frm[c], "R10/R8 frame count",
            int'(frame_cnt[c*CW +: CW]), m_frm[c]);
        chk(int'(dac_valid[c]) == m_dv[c], "R6/R8 dac valid", int'(dac_valid[c]), m_dv[c]);
        chk(int'(rx_valid[c]) == m_rv[c], "R6/R8 rx valid", int'(rx_valid[c]), m_rv[c]);
        if (m_dv[c] != 0)
          chk(int'(dac_data[c*SW +: SW]) == m_dd[c], "R3/R5/R7/R9 dac data",
              int'(dac_data[c*SW +: SW]), m_dd[c]);
        if (m_rv[c] != 0)
          chk(int'(rx_data[c*SW +: SW]) == m_rd[c], "R3/R4/R7/R9 rx data",
              int'(rx_data[c*SW +: SW]), m_rd[c]);
      end
    end
  end

  task automatic drive_rand();
    for (int c = 0; c < NCH; c++) begin
      tx_valid[c]  = ($urandom % 3) == 0;
      adc_valid[c] = ($urandom % 3) == 0;
      tx_data[c*SW +: SW]  = SW'($urandom);
      adc_data[c*SW +: SW] = SW'($urandom);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
      drive_rand();
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    drive_rand();
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = RW'(d);
  endtask

  // write issued in the same cycle as a boundary of channel ch
  task automatic wr_on_sync(input int ch, input int a, input int d);
    do begin
      @(negedge clk);
      wr_en = 1'b0;
      drive_rand();
    end while (!sync[ch]);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = RW'(d);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int f0, f1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(dac_valid == '0 && rx_valid == '0, "R1 valids after reset", int'(dac_valid), 0);
    chk(frame_cnt == '0, "R1 counters after reset", int'(frame_cnt), 0);
    rst_n = 1'b1;
    step(5 * DIV);                       // R3 normal routing
    wr(1, 8'h10); wr(3, 8'h20);          // R4 on data, R5 on voice
    step(6 * DIV);
    wr(1, 8'h30);                        // R5: both bits, host-side echo wins
    step(6 * DIV);
    // R2: stray addresses ignored
    f0 = int'(frame_cnt[0 +: CW]);
    wr(0, 8'h40); wr(2, 8'h40);
    step(3 * DIV);
    chk(int'(frame_cnt[0 +: CW]) != f0, "R2 stray write left channel 0 running",
        int'(frame_cnt[0 +: CW]), f0 + 3);
    // R7: write on a boundary cycle
    wr_on_sync(0, 1, 8'h10);
    step(4 * DIV);
    wr_on_sync(1, 3, 8'h00);
    step(4 * DIV);
    // R8/R9: power down data channel on a boundary, voice keeps running
    wr_on_sync(0, 1, 8'h50);
    step(2);
    f1 = int'(frame_cnt[CW +: CW]);
    step(4 * DIV);
    chk(int'(frame_cnt[0 +: CW]) == 0, "R8 powered-down counter", int'(frame_cnt[0 +: CW]), 0);
    chk(sync[0] == 1'b0, "R8 no sync while down", int'(sync[0]), 0);
    chk(int'(frame_cnt[CW +: CW]) == (f1 + 4) % 256, "R9 voice unaffected",
        int'(frame_cnt[CW +: CW]), (f1 + 4) % 256);
    wr(1, 8'h10);                        // R8 leave power-down, echo resumes
    step(6 * DIV);
    wr(3, 8'h60);                        // R9 voice down, data keeps running
    step(6 * DIV);
    wr(3, 8'h00);
    step(300 * DIV);                     // R10 wrap of the boundary counter
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule